// File: doc/BRIEF.md
# Smart Card Waiting and Guard Time Timer

This block times the character stream on a smart card line in units of the elementary time unit (ETU). The transceiver sends it three kinds of event: a one-cycle strobe per ETU, a pulse at the leading edge of each received start bit, and a pulse at the leading edge of each transmitted start bit. The host configures the block through a small write-only register port.

On the receive side the block watches one timeout at a time, chosen by the host. The initial wait runs from the moment it is armed until the card's first start bit. The character wait restarts at every received start bit. The block wait runs from the start bit of the last transmitted character until the card answers. If the chosen timeout reaches the host-loaded wait value, a sticky flag is set and the interrupt is raised.

On the transmit side the block gates a transmit-permit output. Transmitted characters are spaced by at least 12 ETUs plus a programmable extra guard. When the previous character was received, a programmable block guard spacing must also have passed.

Top module: `sc_wait_timer`

## Requirements
- R1: After reset all timeout flags and the interrupt are low, no timeout is armed, and `tx_ok_o` is high while `tx_mode_i` is high, because no character has been seen yet.
- R2: `tx_ok_o` is low whenever `tx_mode_i` is low.
- R3: When the last start edge was a transmitted one, `tx_ok_o` drops in the cycle after that edge. It stays low until 12 plus the extra guard value (address 1, 8 bits) ETU strobes have been counted.
- R4: When the last start edge was a received one, the spacing required before `tx_ok_o` rises is the larger of 12 plus the extra guard and the block guard value (address 2, 8 bits).
- R5: Register port: address 0 takes the 24-bit wait value, address 3 arms a timeout from data[1:0] (0 none, 1 initial, 2 character, 3 block), and address 4 clears the flags selected by data[2:0]. Flag bit 0 is the initial wait, bit 1 the character wait and bit 2 the block wait.
- R6: An armed initial wait counts from the arm write. Its flag sets on the ETU strobe that brings the count to the wait value; a wait value of 0 behaves as 1. A received start edge before expiry cancels it.
- R7: An armed character wait does not count before the first received start edge. Each received start edge restarts it from zero.
- R8: An armed block wait restarts from zero at each transmitted start edge and is stopped by a received start edge.
- R9: A flag stays set until a clear write has its bit set. Clearing one bit leaves the others unchanged. `irq_o` is high while any flag is set.
- R10: Only the armed timeout type can set its flag. At most one flag rises in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| etu_i | input | 1 | One-cycle strobe per elapsed ETU |
| rx_start_i | input | 1 | Leading edge of a received start bit |
| tx_start_i | input | 1 | Leading edge of a transmitted start bit |
| tx_mode_i | input | 1 | High when the interface is in transmit direction |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 24 | Register write data |
| tx_ok_o | output | 1 | Next character may be transmitted |
| tmo_flags_o | output | 3 | Sticky timeout flags: initial, character, block |
| irq_o | output | 1 | Any timeout flag set |

## Verification
The bench walks the transmit permit across both sides of each spacing threshold. It covers cases where the block guard wins and cases where the extra guard wins. A design that used the wrong comparison or ignored the last direction would release one ETU early or late. Each timeout type is checked one strobe before and one strobe at expiry. The restart, cancel and not-yet-started cases are checked separately, so that a counter which ignored its restart event or counted before its start event would raise a flag the bench does not expect. Partial flag clears and events for an unarmed type are checked to catch flags that are lost or set by the wrong timeout.

// File: rtl/sc_wt_pkg.sv
package sc_wt_pkg;
  typedef enum logic [1:0] {
    TMO_OFF = 2'd0,
    TMO_IWT = 2'd1,
    TMO_CWT = 2'd2,
    TMO_BWT = 2'd3
  } tmo_e;

  localparam logic [2:0] A_WAIT = 3'd0;
  localparam logic [2:0] A_EGT  = 3'd1;
  localparam logic [2:0] A_BGT  = 3'd2;
  localparam logic [2:0] A_ARM  = 3'd3;
  localparam logic [2:0] A_CLR  = 3'd4;
endpackage

// File: rtl/sc_wt_regs.sv
module sc_wt_regs
  import sc_wt_pkg::*;
#(
  parameter int WAIT_W = 24,
  parameter int GT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [WAIT_W-1:0] wr_data_i,
  output logic [WAIT_W-1:0] wait_o,
  output logic [GT_W-1:0]   egt_o,
  output logic [GT_W-1:0]   bgt_o,
  output tmo_e              sel_o,
  output logic              arm_o,
  output tmo_e              arm_sel_o,
  output logic [2:0]        clr_o
);
  assign arm_o     = wr_en_i && (wr_addr_i == A_ARM);
  assign arm_sel_o = tmo_e'(wr_data_i[1:0]);
  assign clr_o     = (wr_en_i && (wr_addr_i == A_CLR)) ? wr_data_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_o <= '0;
      egt_o  <= '0;
      bgt_o  <= '0;
      sel_o  <= TMO_OFF;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_WAIT:  wait_o <= wr_data_i;
        A_EGT:   egt_o  <= wr_data_i[GT_W-1:0];
        A_BGT:   bgt_o  <= wr_data_i[GT_W-1:0];
        A_ARM:   sel_o  <= arm_sel_o;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sc_wt_wait.sv
module sc_wt_wait
  import sc_wt_pkg::*;
#(
  parameter int WAIT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              etu_i,
  input  logic              rx_start_i,
  input  logic              tx_start_i,
  input  tmo_e              sel_i,
  input  logic              arm_i,
  input  tmo_e              arm_sel_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [2:0]        clr_i,
  output logic [2:0]        flags_o
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [WAIT_W:0]   cnt_nxt;
  logic              run_q, run_d, fire;
  logic [2:0]        fire_vec;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    fire  = 1'b0;
    if (arm_i) begin
      cnt_d = '0;
      run_d = (arm_sel_i == TMO_IWT);
    end else if (sel_i == TMO_OFF) begin
      run_d = 1'b0;
    end else if (rx_start_i) begin
      // character wait restarts, the others stop
      cnt_d = '0;
      run_d = (sel_i == TMO_CWT);
    end else if (tx_start_i && sel_i == TMO_BWT) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q && etu_i) begin
      if (cnt_nxt >= {1'b0, wait_i}) begin
        run_d = 1'b0;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_nxt[WAIT_W-1:0];
      end
    end
  end

  always_comb begin
    case (sel_i)
      TMO_IWT: fire_vec = {2'b00, fire};
      TMO_CWT: fire_vec = {1'b0, fire, 1'b0};
      TMO_BWT: fire_vec = {fire, 2'b00};
      default: fire_vec = 3'b000;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      flags_o <= '0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      flags_o <= (flags_o & ~clr_i) | fire_vec;
    end
  end
endmodule

// File: rtl/sc_wt_guard.sv
module sc_wt_guard #(
  parameter int GT_W     = 8,
  parameter int CHAR_ETU = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            etu_i,
  input  logic            rx_start_i,
  input  logic            tx_start_i,
  input  logic            tx_mode_i,
  input  logic [GT_W-1:0] egt_i,
  input  logic [GT_W-1:0] bgt_i,
  output logic            tx_ok_o
);
  localparam int GC_W = GT_W + 2;
  localparam logic [GC_W-1:0] CHR = GC_W'(CHAR_ETU);
  localparam logic [GC_W-1:0] SAT = '1;

  logic [GC_W-1:0] gap_q, req_chr, req_blk, req;
  logic            seen_q, last_rx_q;

  assign req_chr = CHR + GC_W'(egt_i);
  assign req_blk = GC_W'(bgt_i);
  assign req     = (last_rx_q && req_blk > req_chr) ? req_blk : req_chr;
  assign tx_ok_o = tx_mode_i && (!seen_q || gap_q >= req);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      last_rx_q <= 1'b0;
    end else if (rx_start_i) begin
      gap_q     <= '0;
      seen_q    <= 1'b1;
      last_rx_q <= 1'b1;
    end else if (tx_start_i) begin
      gap_q     <= '0;
      seen_q    <= 1'b1;
      last_rx_q <= 1'b0;
    end else if (etu_i && gap_q != SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer
  import sc_wt_pkg::*;
#(
  parameter int WAIT_W   = 24,
  parameter int GT_W     = 8,
  parameter int CHAR_ETU = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              etu_i,
  input  logic              rx_start_i,
  input  logic              tx_start_i,
  input  logic              tx_mode_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [WAIT_W-1:0] wr_data_i,
  output logic              tx_ok_o,
  output logic [2:0]        tmo_flags_o,
  output logic              irq_o
);
  logic [WAIT_W-1:0] wait_v;
  logic [GT_W-1:0]   egt_v, bgt_v;
  tmo_e              sel, arm_sel;
  logic              arm;
  logic [2:0]        clr;

  sc_wt_regs #(.WAIT_W(WAIT_W), .GT_W(GT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .wait_o(wait_v), .egt_o(egt_v), .bgt_o(bgt_v),
    .sel_o(sel), .arm_o(arm), .arm_sel_o(arm_sel), .clr_o(clr)
  );

  sc_wt_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i, .rst_ni, .etu_i, .rx_start_i, .tx_start_i,
    .sel_i(sel), .arm_i(arm), .arm_sel_i(arm_sel),
    .wait_i(wait_v), .clr_i(clr), .flags_o(tmo_flags_o)
  );

  sc_wt_guard #(.GT_W(GT_W), .CHAR_ETU(CHAR_ETU)) u_guard (
    .clk_i, .rst_ni, .etu_i, .rx_start_i, .tx_start_i, .tx_mode_i,
    .egt_i(egt_v), .bgt_i(bgt_v), .tx_ok_o
  );

  assign irq_o = |tmo_flags_o;
endmodule

// File: rtl/sc_wait_timer_chk.sv
module sc_wait_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       etu_i,
  input logic       rx_start_i,
  input logic       tx_start_i,
  input logic       tx_mode_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [2:0] clr_bits_i,
  input logic       tx_ok_o,
  input logic [2:0] tmo_flags_o
);
  logic [2:0] clr_req;
  assign clr_req = (wr_en_i && wr_addr_i == 3'd4) ? clr_bits_i : 3'b000;

  // R2
  no_permit_in_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_mode_i |-> !tx_ok_o);

  // R3
  tx_start_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i && !rx_start_i |=> !tx_ok_o);

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((tmo_flags_o & ($past(tmo_flags_o) & ~$past(clr_req)))
              == ($past(tmo_flags_o) & ~$past(clr_req))));

  // R10
  one_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(tmo_flags_o & ~$past(tmo_flags_o)) <= 1);

  // R6
  rise_on_etu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((tmo_flags_o & ~$past(tmo_flags_o)) == 3'b000
              || ($past(etu_i) && !$past(rx_start_i))));
endmodule

bind sc_wait_timer sc_wait_timer_chk u_chk (
  .clk_i, .rst_ni, .etu_i, .rx_start_i, .tx_start_i, .tx_mode_i,
  .wr_en_i, .wr_addr_i, .clr_bits_i(wr_data_i[2:0]), .tx_ok_o, .tmo_flags_o
);

// File: tb/sc_wait_timer_test.sv
module sc_wait_timer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        etu = 1'b0, rx_s = 1'b0, tx_s = 1'b0, tx_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        tx_ok, irq;
  logic [2:0]  flags;
  int          errs = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  sc_wait_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .etu_i(etu), .rx_start_i(rx_s),
    .tx_start_i(tx_s), .tx_mode_i(tx_mode), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tx_ok_o(tx_ok), .tmo_flags_o(flags), .irq_o(irq)
  );

  typedef struct packed {
    logic       rx;
    logic [7:0] egt;
    logic [7:0] bgt;
    logic [9:0] n;
    logic       ok;
  } vec_t;

  // spacing vectors: R3 rows use a tx edge, R4 rows an rx edge
  localparam vec_t VEC [8] = '{
    '{1'b0, 8'd0,  8'd0,  10'd11, 1'b0},
    '{1'b0, 8'd0,  8'd0,  10'd12, 1'b1},
    '{1'b0, 8'd3,  8'd0,  10'd14, 1'b0},
    '{1'b0, 8'd3,  8'd0,  10'd15, 1'b1},
    '{1'b1, 8'd0,  8'd20, 10'd19, 1'b0},
    '{1'b1, 8'd0,  8'd20, 10'd20, 1'b1},
    '{1'b1, 8'd10, 8'd5,  10'd21, 1'b0},
    '{1'b1, 8'd10, 8'd5,  10'd22, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic etus(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); etu = 1'b1;
      @(negedge clk); etu = 1'b0;
    end
  endtask

  task automatic rx_edge();
    @(negedge clk); rx_s = 1'b1;
    @(negedge clk); rx_s = 1'b0;
  endtask

  task automatic tx_edge();
    @(negedge clk); tx_s = 1'b1;
    @(negedge clk); tx_s = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
    check("R1 tx_ok", tx_ok, 1);
    tx_mode = 1'b0;
    @(negedge clk);
    check("R2 tx_ok rx mode", tx_ok, 0);
    tx_mode = 1'b1;

    tx_edge();
    check("R3 drop after tx edge", tx_ok, 0);

    for (int v = 0; v < 8; v++) begin
      wr(3'd1, 24'(VEC[v].egt));
      wr(3'd2, 24'(VEC[v].bgt));
      if (VEC[v].rx) rx_edge(); else tx_edge();
      etus(int'(VEC[v].n));
      check(VEC[v].rx ? "R4 spacing" : "R3 spacing", tx_ok, int'(VEC[v].ok));
    end
    tx_mode = 1'b0;
    @(negedge clk);
    check("R2 tx_ok after gap", tx_ok, 0);
    tx_mode = 1'b1;

    // R6 initial wait
    wr(3'd0, 24'd5);
    wr(3'd3, 24'd1);
    etus(4);
    check("R6 iwt before", flags, 0);
    etus(1);
    check("R6 iwt expire", flags, 3'b001);
    check("R9 irq", irq, 1);
    wr(3'd4, 24'd7);
    check("R9 clear all", flags, 0);
    wr(3'd3, 24'd1);
    etus(3);
    rx_edge();
    etus(10);
    check("R6 iwt cancel", flags, 0);
    wr(3'd0, 24'd0);
    wr(3'd3, 24'd1);
    etus(1);
    check("R6 wait zero", flags, 3'b001);
    wr(3'd4, 24'd1);

    // R7 character wait
    wr(3'd0, 24'd4);
    wr(3'd3, 24'd2);
    etus(10);
    check("R7 cwt not started", flags, 0);
    rx_edge(); etus(3);
    rx_edge(); etus(3);
    check("R7 cwt restart", flags, 0);
    etus(1);
    check("R7 cwt expire", flags, 3'b010);
    rx_edge(); tx_edge(); etus(5);
    check("R9 sticky", flags, 3'b010);
    wr(3'd4, 24'd1);
    check("R9 partial clear", flags, 3'b010);
    wr(3'd4, 24'd2);
    check("R9 clear cwt", flags, 0);
    check("R9 irq low", irq, 0);

    // R10 tx edges do nothing while character wait is armed
    wr(3'd3, 24'd2);
    tx_edge();
    etus(10);
    check("R10 unarmed type", flags, 0);

    // R8 block wait
    wr(3'd0, 24'd6);
    wr(3'd3, 24'd3);
    tx_edge(); etus(3);
    tx_edge(); etus(5);
    check("R8 bwt restart", flags, 0);
    etus(1);
    check("R8 bwt expire", flags, 3'b100);
    wr(3'd4, 24'd4);
    tx_edge(); etus(4);
    rx_edge(); etus(10);
    check("R8 bwt stopped", flags, 0);

    // R5 disarm
    wr(3'd3, 24'd0);
    tx_edge(); etus(10);
    check("R5 disarmed", flags, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule